// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds a set of chip-level configuration words behind a word-addressed write/read bus, and guards them against stray software writes. Each of a small number of "guarded" words has its own lock register: a write of that lock's secret key opens a short write window, and the guarded word accepts writes only while that window is open. The window shuts by itself a fixed number of clock cycles after the key write. A further configuration word is protected by two global key registers that must both hold their own keys at the same time. Some of its bits are enable-only: once a 1 lands in such a bit, no later write clears it.

Writes that arrive while a word is guarded are dropped and recorded in a sticky violation word. Every address can be read at any time, and lock and key registers read back whether they are currently open. The configuration words drive enable and setup vectors out to peripherals.

The address map for the default of four guarded words is: guarded words at 0..3, their locks at 4..7, the two global key registers at 8 and 9, the dual-key word at 10, the violation word at 11. Other addresses read zero and ignore writes. The read path is combinational from the address.

Top module: `keyed_cfg_bank`

## Requirements
- R1: Writing the exact key of lock i (address 4+i) opens its window, and a write to guarded word i (address i) during the open window is stored and read back.
- R2: A correct key write at clock edge t lets guarded writes through at edges t+1 to t+WINDOW (WINDOW defaults to 4). From edge t+WINDOW+1 on the word is guarded again and writes are dropped.
- R3: Writing zero to a lock register closes its window at once, so the next guarded write is dropped.
- R4: Writing any non-matching value to a lock register leaves it closed and closes an already open window.
- R5: A repeated correct key write while the window is open reloads the full window length.
- R6: The dual-key word at address 10 accepts a write only while address 8 holds the first global key and address 9 holds the second. Writing zero to either key register locks it again.
- R7: Bits of the dual-key word selected by the enable-only mask (default bits 7:0) can be set but never cleared by a write. The other bits take the written value.
- R8: A write to a guarded word while it is locked leaves the word unchanged and sets a sticky bit in the violation word at address 11: bit i for guarded word i, bit 4 for the dual-key word.
- R9: A lock register reads 1 in bit 0 while its window is open and 0 otherwise. A global key register reads 1 while it holds its key and 0 otherwise.
- R10: After reset every readable register and every output is zero and all windows are closed.
- R11: `cfg_vec_o` carries guarded word i on bits i*32 up to i*32+31, and `kick_cfg_o` carries the dual-key word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| cfg_vec_o | output | NUM_GUARDED*DATA_W (128) | Guarded words, word 0 in the low bits |
| kick_cfg_o | output | DATA_W (32) | Dual-key protected word |

## Verification
Guarded writes are placed on every cycle of an opened window and one cycle past its end. This separates an off-by-one window length from a correct one. Closing a window with zero, with a wrong key and with a key reload shows each way the counter can change. The dual-key word is written with no key, with one key and with both keys, and the key is then removed again. Writes that try to clear enable-only bits and change free bits in the same word show that the mask is applied per bit. Violation bits are read after each dropped write to confirm which word is blamed.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

   // Kind of register an address resolves to
   typedef enum logic [2:0] {
      SEL_DATA     = 3'd0,
      SEL_LOCK     = 3'd1,
      SEL_KICK_A   = 3'd2,
      SEL_KICK_B   = 3'd3,
      SEL_KICK_CFG = 3'd4,
      SEL_STATUS   = 3'd5,
      SEL_NONE     = 3'd6
   } reg_sel_e;

   // Number of addresses that follow the guarded words and their locks
   localparam int unsigned TAIL_REGS = 4;

endpackage

// File: rtl/cfgbank_lock_win.sv
// One lock register with its self-closing write window.
module cfgbank_lock_win #(
   parameter int unsigned          DATA_W = 32,
   parameter logic [DATA_W-1:0]    KEY    = '1,
   parameter int unsigned          WINDOW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              open_o
);
   localparam int unsigned CNT_W = $clog2(WINDOW + 1);

   if (WINDOW < 1) begin : g_bad_window
      $error("cfgbank_lock_win: WINDOW must be at least 1");
   end
   if (KEY == '0) begin : g_bad_key
      $error("cfgbank_lock_win: KEY of zero cannot be told from a relock");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (key_wr) begin
         cnt_q <= (key_data == KEY) ? CNT_W'(WINDOW) : '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign open_o = (cnt_q != '0);

   // R1: matching key opens the window on the next cycle
   p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data == KEY) |=> open_o);

   // R4 (and R3, zero is never the key): a wrong key leaves it closed
   p_bad_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data != KEY) |=> !open_o);

   // R2: a closed window never opens without a key write
   p_stay_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_o && !key_wr) |=> !open_o);

endmodule

// File: rtl/cfgbank_kick.sv
// Pair of global key registers; unlocked while both hold their keys.
module cfgbank_kick #(
   parameter int unsigned       DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A  = '1,
   parameter logic [DATA_W-1:0] KEY_B  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] wdata,
   output logic              hold_a_o,
   output logic              hold_b_o,
   output logic              unlocked_o
);
   if (KEY_A == '0 || KEY_B == '0) begin : g_bad_keys
      $error("cfgbank_kick: global keys must be nonzero");
   end

   logic [DATA_W-1:0] a_q, b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (wr_a) a_q <= wdata;
         if (wr_b) b_q <= wdata;
      end
   end

   assign hold_a_o   = (a_q == KEY_A);
   assign hold_b_o   = (b_q == KEY_B);
   assign unlocked_o = hold_a_o && hold_b_o;

   // R6: unlock state moves only on a key register write
   p_kick_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_a || wr_b) |=> $stable(unlocked_o));

   // R6: zero to either key register relocks
   p_kick_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_a || wr_b) && wdata == '0) |=> !unlocked_o);

endmodule

// File: rtl/cfgbank_wo_reg.sv
// Config word whose masked bits are enable-only (set, never cleared).
module cfgbank_wo_reg #(
   parameter int unsigned       DATA_W  = 32,
   parameter logic [DATA_W-1:0] WO_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (WO_MASK[b]) begin : g_sticky
         assign nxt[b] = q[b] | wdata[b];
      end else begin : g_plain
         assign nxt[b] = wdata[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end

   // R7: no enable-only bit ever falls
   p_wo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (($past(q) & WO_MASK) & ~q) == '0);

   // R8: without a write strobe the word holds
   p_wo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
   import cfgbank_pkg::*;
#(
   parameter int unsigned                     DATA_W       = 32,
   parameter int unsigned                     ADDR_W       = 4,
   parameter int unsigned                     NUM_GUARDED  = 4,
   parameter int unsigned                     WINDOW       = 4,
   parameter logic [NUM_GUARDED*DATA_W-1:0]   LOCK_KEYS    =
      {32'hA5A5_0013, 32'hA5A5_0012, 32'hA5A5_0011, 32'hA5A5_0010},
   parameter logic [DATA_W-1:0]               GUARD_WO_MASK = '0,
   parameter logic [DATA_W-1:0]               KICK_KEY_A   = 32'h83E7_0B13,
   parameter logic [DATA_W-1:0]               KICK_KEY_B   = 32'h95A4_F1E0,
   parameter logic [DATA_W-1:0]               KICK_WO_MASK = 32'h0000_00FF
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   output logic [NUM_GUARDED*DATA_W-1:0] cfg_vec_o,
   output logic [DATA_W-1:0]             kick_cfg_o
);
   localparam int unsigned IDX_W   = (NUM_GUARDED > 1) ? $clog2(NUM_GUARDED) : 1;
   localparam int unsigned VIOL_W  = NUM_GUARDED + 1;
   localparam int unsigned N_ADDRS = 2 * NUM_GUARDED + TAIL_REGS;

   localparam logic [ADDR_W-1:0] A_LOCK0  = ADDR_W'(NUM_GUARDED);
   localparam logic [ADDR_W-1:0] A_KICK_A = ADDR_W'(2 * NUM_GUARDED);
   localparam logic [ADDR_W-1:0] A_KICK_B = ADDR_W'(2 * NUM_GUARDED + 1);
   localparam logic [ADDR_W-1:0] A_KCFG   = ADDR_W'(2 * NUM_GUARDED + 2);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(2 * NUM_GUARDED + 3);

   // Elaboration-time parameter checks
   if (NUM_GUARDED < 1 || NUM_GUARDED > 8) begin : g_bad_count
      $error("keyed_cfg_bank: NUM_GUARDED must be 1..8");
   end
   if (N_ADDRS > (1 << ADDR_W)) begin : g_bad_addr
      $error("keyed_cfg_bank: ADDR_W too narrow for the register map");
   end
   if (VIOL_W > DATA_W) begin : g_bad_viol
      $error("keyed_cfg_bank: violation word wider than the data bus");
   end

   // ---------------- address decode ----------------
   reg_sel_e         sel;
   logic [IDX_W-1:0] idx;

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (bus_addr < A_LOCK0) begin
         sel = SEL_DATA;
         idx = IDX_W'(bus_addr);
      end else if (bus_addr < A_KICK_A) begin
         sel = SEL_LOCK;
         idx = IDX_W'(bus_addr - A_LOCK0);
      end else if (bus_addr == A_KICK_A) begin
         sel = SEL_KICK_A;
      end else if (bus_addr == A_KICK_B) begin
         sel = SEL_KICK_B;
      end else if (bus_addr == A_KCFG) begin
         sel = SEL_KICK_CFG;
      end else if (bus_addr == A_STAT) begin
         sel = SEL_STATUS;
      end
   end

   // ---------------- guarded words with single locks ----------------
   logic [DATA_W-1:0]      data_q [NUM_GUARDED];
   logic [NUM_GUARDED-1:0] open_v;
   logic [VIOL_W-1:0]      viol_set;

   for (genvar i = 0; i < NUM_GUARDED; i++) begin : g_guard
      logic key_wr;
      logic data_wr;

      assign key_wr  = bus_we && (sel == SEL_LOCK) && (idx == IDX_W'(i));
      assign data_wr = bus_we && (sel == SEL_DATA) && (idx == IDX_W'(i));

      cfgbank_lock_win #(
         .DATA_W (DATA_W),
         .KEY    (LOCK_KEYS[i*DATA_W +: DATA_W]),
         .WINDOW (WINDOW)
      ) u_lock (
         .clk      (clk),
         .rst_n    (rst_n),
         .key_wr   (key_wr),
         .key_data (bus_wdata),
         .open_o   (open_v[i])
      );

      cfgbank_wo_reg #(
         .DATA_W  (DATA_W),
         .WO_MASK (GUARD_WO_MASK)
      ) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (data_wr && open_v[i]),
         .wdata (bus_wdata),
         .q     (data_q[i])
      );

      assign viol_set[i] = data_wr && !open_v[i];
      assign cfg_vec_o[i*DATA_W +: DATA_W] = data_q[i];

      // R8: a write to a locked word changes nothing
      p_drop_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && !open_v[i]) |=> $stable(data_q[i]));

      // R1: an open window lets the write land (plain bits)
      p_accept_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && open_v[i]) |=>
            ((data_q[i] & ~GUARD_WO_MASK) == ($past(bus_wdata) & ~GUARD_WO_MASK)));
   end

   // ---------------- dual-key protected word ----------------
   logic hold_a, hold_b, kick_open;
   logic kcfg_wr;

   cfgbank_kick #(
      .DATA_W (DATA_W),
      .KEY_A  (KICK_KEY_A),
      .KEY_B  (KICK_KEY_B)
   ) u_kick (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_a       (bus_we && sel == SEL_KICK_A),
      .wr_b       (bus_we && sel == SEL_KICK_B),
      .wdata      (bus_wdata),
      .hold_a_o   (hold_a),
      .hold_b_o   (hold_b),
      .unlocked_o (kick_open)
   );

   assign kcfg_wr = bus_we && (sel == SEL_KICK_CFG);

   cfgbank_wo_reg #(
      .DATA_W  (DATA_W),
      .WO_MASK (KICK_WO_MASK)
   ) u_kcfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (kcfg_wr && kick_open),
      .wdata (bus_wdata),
      .q     (kick_cfg_o)
   );

   assign viol_set[NUM_GUARDED] = kcfg_wr && !kick_open;

   // R6: dual-key word holds while either key is missing
   p_kick_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kcfg_wr && !kick_open) |=> $stable(kick_cfg_o));

   // ---------------- sticky violation word ----------------
   logic [VIOL_W-1:0] viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol_q <= '0;
      else        viol_q <= viol_q | viol_set;
   end

   // R8: violation bits never clear outside reset
   p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($past(viol_q) & ~viol_q) == '0);

   // ---------------- read path (R9) ----------------
   always_comb begin
      unique case (sel)
         SEL_DATA:     bus_rdata = data_q[idx];
         SEL_LOCK:     bus_rdata = DATA_W'(open_v[idx]);
         SEL_KICK_A:   bus_rdata = DATA_W'(hold_a);
         SEL_KICK_B:   bus_rdata = DATA_W'(hold_b);
         SEL_KICK_CFG: bus_rdata = kick_cfg_o;
         SEL_STATUS:   bus_rdata = DATA_W'(viol_q);
         default:      bus_rdata = '0;
      endcase
   end

endmodule

// File: tb/keyed_cfg_bank_test.sv
module keyed_cfg_bank_test;

   localparam logic [3:0] D0 = 4'd0, D1 = 4'd1, D2 = 4'd2, D3 = 4'd3;
   localparam logic [3:0] L0 = 4'd4, L1 = 4'd5, L2 = 4'd6, L3 = 4'd7;
   localparam logic [3:0] KA = 4'd8, KB = 4'd9, KC = 4'd10, ST = 4'd11;
   localparam logic [31:0] K0 = 32'hA5A5_0010, K1 = 32'hA5A5_0011;
   localparam logic [31:0] K2 = 32'hA5A5_0012, K3 = 32'hA5A5_0013;
   localparam logic [31:0] GA = 32'h83E7_0B13, GB = 32'h95A4_F1E0;

   typedef struct packed {
      logic        wr;
      logic [3:0]  addr;
      logic [31:0] wdata;
      logic [3:0]  raddr;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 42;
   // Each row takes exactly one clock: optional write, then a read check.
   localparam vec_t VEC [NV] = '{
      {1'b1, L0, K0,            L0, 32'd1,         4'd1}, // R1 key opens
      {1'b1, D0, 32'h1234,      D0, 32'h1234,      4'd1}, // R1 write lands
      {1'b1, L0, 32'd0,         L0, 32'd0,         4'd3}, // R3 zero closes
      {1'b1, D0, 32'h5555,      D0, 32'h1234,      4'd3}, // R3 dropped
      {1'b0, D0, 32'd0,         ST, 32'h1,         4'd8}, // R8 bit0
      {1'b1, L1, K1,            L1, 32'd1,         4'd2}, // R2 open t
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2}, // t+1
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2}, // t+2
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2}, // t+3
      {1'b1, D1, 32'hAAAA,      D1, 32'hAAAA,      4'd2}, // R2 last slot t+4
      {1'b0, D0, 32'd0,         L1, 32'd0,         4'd2}, // R2 closed
      {1'b1, L1, K1,            L1, 32'd1,         4'd2}, // reopen t
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2},
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2},
      {1'b0, D0, 32'd0,         L1, 32'd1,         4'd2},
      {1'b0, D0, 32'd0,         L1, 32'd0,         4'd2}, // t+4 idle used up
      {1'b1, D1, 32'hBBBB,      D1, 32'hAAAA,      4'd2}, // R2 t+5 dropped
      {1'b0, D0, 32'd0,         ST, 32'h3,         4'd8}, // R8 bit1
      {1'b1, L2, K2,            L2, 32'd1,         4'd4},
      {1'b1, L2, 32'hDEAD_0001, L2, 32'd0,         4'd4}, // R4 wrong key
      {1'b1, D2, 32'h77,        D2, 32'd0,         4'd4}, // R4 dropped
      {1'b0, D0, 32'd0,         ST, 32'h7,         4'd8}, // R8 bit2
      {1'b1, L3, K3,            L3, 32'd1,         4'd5}, // R5 t
      {1'b0, D0, 32'd0,         L3, 32'd1,         4'd5},
      {1'b0, D0, 32'd0,         L3, 32'd1,         4'd5},
      {1'b1, L3, K3,            L3, 32'd1,         4'd5}, // R5 reload t+3
      {1'b0, D0, 32'd0,         L3, 32'd1,         4'd5},
      {1'b0, D0, 32'd0,         L3, 32'd1,         4'd5},
      {1'b0, D0, 32'd0,         L3, 32'd1,         4'd5},
      {1'b1, D3, 32'h99,        D3, 32'h99,        4'd5}, // R5 t+7 lands
      {1'b1, KC, 32'hFF0F,      KC, 32'd0,         4'd6}, // R6 no keys
      {1'b0, D0, 32'd0,         ST, 32'h17,        4'd8}, // R8 bit4
      {1'b1, KA, GA,            KA, 32'd1,         4'd9}, // R9 key held
      {1'b1, KC, 32'h0F,        KC, 32'd0,         4'd6}, // R6 one key only
      {1'b1, KB, GB,            KB, 32'd1,         4'd9},
      {1'b1, KC, 32'hABCD_000F, KC, 32'hABCD_000F, 4'd6}, // R6 both keys
      {1'b1, KC, 32'h1234_0003, KC, 32'h1234_000F, 4'd7}, // R7 no clear
      {1'b1, KC, 32'h0000_00F0, KC, 32'h0000_00FF, 4'd7}, // R7 set more
      {1'b1, KA, 32'd0,         KA, 32'd0,         4'd6}, // R6 relock
      {1'b1, KC, 32'd0,         KC, 32'h0000_00FF, 4'd6}, // R6 dropped
      {1'b1, KB, 32'h1,         KB, 32'd0,         4'd9}, // R9 wrong value
      {1'b0, D0, 32'd0,         ST, 32'h17,        4'd8}  // R8 final
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [127:0]  cfg_vec_o;
   logic [31:0]   kick_cfg_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   keyed_cfg_bank uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cfg_vec_o  (cfg_vec_o),
      .kick_cfg_o (kick_cfg_o)
   );

   task automatic check(input logic [127:0] act, input logic [127:0] exp,
                        input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state of every address and both outputs
      for (int a = 0; a < 12; a++) begin
         bus_addr = 4'(a);
         #1 check(128'(bus_rdata), 128'd0, $sformatf("R10 addr %0d", a));
      end
      check(cfg_vec_o, 128'd0, "R10 cfg_vec_o");
      check(128'(kick_cfg_o), 128'd0, "R10 kick_cfg_o");
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         bus_we    = VEC[k].wr;
         bus_addr  = VEC[k].addr;
         bus_wdata = VEC[k].wdata;
         @(posedge clk);
         #2;
         bus_we   = 1'b0;
         bus_addr = VEC[k].raddr;
         #1 check(128'(bus_rdata), 128'(VEC[k].exp),
                  $sformatf("R%0d row %0d", VEC[k].req, k));
      end

      // R11: output ports mirror the stored words
      @(negedge clk);
      check(cfg_vec_o, {32'h99, 32'h0, 32'hAAAA, 32'h1234}, "R11 cfg_vec_o");
      check(128'(kick_cfg_o), 128'h0000_00FF, "R11 kick_cfg_o");

      // R10: a reset in mid-run clears everything again
      rst_n = 1'b0;
      #1;
      check(cfg_vec_o, 128'd0, "R10 cfg_vec_o after reset");
      check(128'(kick_cfg_o), 128'd0, "R10 kick_cfg_o after reset");
      bus_addr = ST;
      #1 check(128'(bus_rdata), 128'd0, "R10 violation word after reset");
      bus_addr = L3;
      #1 check(128'(bus_rdata), 128'd0, "R10 lock closed after reset");
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               checks++;
               errors++;
               $display("FAIL watchdog actual=hung expected=done");
            end
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule